// File: doc/BRIEF.md
# Transmit Frame Check Sequence Append Unit

This block sits in the transmit path of an Ethernet MAC, between the frame source and the PHY-side serialiser. It takes a byte stream in which the first byte carries a start marker and the final byte an end marker. The start byte also carries a control bit that chooses how the 32-bit frame check sequence is handled for that frame. When the bit is clear, the block computes the standard Ethernet CRC-32 over every byte it receives and emits four check bytes after the last data byte. When the bit is set, the block treats the last four bytes it receives as the check sequence. It forwards them untouched and appends nothing.

A per-frame underflow input marks a frame whose data ran dry upstream. The block records that mark at any point while the frame is coming in. It then sends the frame's check bytes bit-inverted, so every receiver discards the frame. In pass-through mode the block keeps the most recent four bytes in a small hold buffer. This lets it recognise and invert the supplied check bytes once the end marker arrives. The output side uses a valid/ready handshake toward the PHY interface.

Top module: `fcs_tx_append`

## Requirements
- R1: After reset the block is idle: `out_valid` is 0 and `in_ready` is 1.
- R2: With the start-byte control bit clear (generate mode), every input byte is forwarded unchanged and in order. Four check bytes follow it. The check value uses the reflected polynomial 0xEDB88320 with a register preset to 0xFFFFFFFF, and the result is complemented. The bytes go out least significant first. `out_last` is 1 only on the fourth check byte.
- R3: In generate mode all input bytes are payload. A frame whose final four bytes already form a valid check value still receives four freshly computed bytes, so the output is four bytes longer than the input.
- R4: With the start-byte control bit set (pass mode), the output byte sequence equals the input sequence in content and count. `out_last` is set on the byte that carried `in_last`, and no bytes are added.
- R5: In pass mode the supplied check bytes are not verified. A frame with a wrong check value is forwarded unchanged.
- R6: In generate mode with underflow marked, each of the four appended bytes is XORed with 0xFF. The data bytes are unaffected.
- R7: In pass mode with underflow marked, the final four bytes of the frame are each XORed with 0xFF. Earlier bytes are unaffected.
- R8: `in_underflow` is recorded on any cycle from the presentation of the start byte to the acceptance of the end byte, whether or not `in_valid` is high in that cycle. The mark is cleared once the frame's last byte has left, so the next frame is unaffected.
- R9: The control bit is sampled only on the start byte. Its value on later bytes of the same frame has no effect.
- R10: While idle, bytes presented without the start marker are accepted (`in_ready` = 1) and discarded, and no output is produced.
- R11: While `out_ready` is 0 a pending output byte stays valid and unchanged. No byte is lost or repeated. `in_ready` is 0 while the check bytes or the held tail bytes are being sent.
- R12: In pass mode no output is valid until four bytes are held. A pass-mode frame must be at least four bytes long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts the input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_last | input | 1 | Input byte is the last of a frame |
| in_pass | input | 1 | Sampled with the start byte: 1 = check bytes supplied, 0 = generate |
| in_underflow | input | 1 | Upstream underflow mark for the current frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the last of the frame |

## Verification
The hardest case to reach is an underflow mark that arrives on a cycle where no byte is offered. The mark must still corrupt that frame's check bytes and must then vanish before the next frame. The stimulus reaches it by inserting idle gaps inside a generate-mode frame and raising `in_underflow` only during the first gap, followed by a clean frame. The other hard case is pass mode under random downstream stalls. There the hold buffer must stream older bytes while still holding exactly the last four. The stimulus combines random `out_ready` and input gaps in a pass frame with an underflow mark on its final byte and on its first byte.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BYTE_W  = 8;
  localparam int FCS_LEN = 4;
  localparam int CRC_W   = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_R = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_SEED   = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {ST_IDLE, ST_GEN, ST_PASS, ST_TAIL} fcs_state_e;
  typedef enum logic [1:0] {SEL_NONE, SEL_IN, SEL_HOLD, SEL_TAIL} out_sel_e;

  // Fold one byte into the running reflected CRC, LSB first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = c_in;
    for (int b = 0; b < BYTE_W; b++) begin
      c = (c >> 1) ^ (CRC_POLY_R & {CRC_W{c[0] ^ d[b]}});
    end
    return c;
  endfunction

  // Byte lane of the transmitted (complemented) check value, lane 0 first.
  function automatic logic [BYTE_W-1:0] fcs_lane(input logic [CRC_W-1:0] c, input int lane);
    logic [CRC_W-1:0] f;
    f = ~c;
    return f[lane*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
  import fcs_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int CW = CRC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fold,
  input  logic [DW-1:0] din,
  output logic [CW-1:0] crc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (start) crc_q <= crc_fold_byte(CRC_SEED, din);
    else if (fold)  crc_q <= crc_fold_byte(crc_q, din);
  end
endmodule

// File: rtl/fcs_tail_hold.sv
module fcs_tail_hold #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [CNT_W-1:0] count
);
  // slot[0] is the oldest byte once the buffer is full; new bytes enter at the top.
  logic [W-1:0] slot [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
    end else if (push) begin
      for (int k = 0; k < DEPTH - 1; k++) slot[k] <= slot[k+1];
      slot[DEPTH-1] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   count <= '0;
    else if (clear)                               count <= push ? CNT_W'(1) : '0;
    else if (push && count != CNT_W'(DEPTH))      count <= count + CNT_W'(1);
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/fcs_tx_ctrl.sv
module fcs_tx_ctrl
  import fcs_pkg::*;
#(
  parameter int TAIL_LEN = FCS_LEN,
  localparam int IDX_W = $clog2(TAIL_LEN),
  localparam int CNT_W = $clog2(TAIL_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_last,
  input  logic             in_pass,
  input  logic             in_underflow,
  input  logic             out_ready,
  input  logic [CNT_W-1:0] hold_count,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_last,
  output out_sel_e         out_sel,
  output logic             crc_start,
  output logic             crc_fold,
  output logic             hold_clear,
  output logic             hold_push,
  output logic [IDX_W-1:0] tail_idx,
  output logic             pass_q,
  output logic             unf_q,
  output fcs_state_e       st
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(TAIL_LEN - 1);

  logic             hold_full, accept, sof_here, frame_open, tail_go, tail_done, pass_now;
  logic [CNT_W-1:0] cnt_after;
  logic [IDX_W-1:0] tidx_first;

  assign hold_full = (hold_count == CNT_W'(TAIL_LEN));
  assign sof_here  = (st == ST_IDLE) && in_valid && in_sof;
  assign pass_now  = (st == ST_IDLE) ? in_pass : pass_q;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_sel   = SEL_NONE;
    unique case (st)
      ST_IDLE: begin
        if (sof_here && !in_pass) begin
          out_valid = 1'b1;
          in_ready  = out_ready;
          out_sel   = SEL_IN;
        end else begin
          in_ready  = 1'b1;
        end
      end
      ST_GEN: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_sel   = SEL_IN;
      end
      ST_PASS: begin
        if (hold_full) begin
          out_valid = in_valid;
          in_ready  = out_ready;
          out_sel   = SEL_HOLD;
        end else begin
          in_ready  = 1'b1;
        end
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_sel   = SEL_TAIL;
        out_last  = (tail_idx == IDX_LAST);
      end
      default: ;
    endcase
  end

  assign accept     = in_valid && in_ready;
  assign crc_start  = sof_here && accept && !in_pass;
  assign crc_fold   = (st == ST_GEN) && accept;
  assign hold_clear = sof_here && accept && in_pass;
  assign hold_push  = hold_clear || ((st == ST_PASS) && accept);
  assign frame_open = (st == ST_GEN) || (st == ST_PASS) || sof_here;
  assign tail_go    = accept && in_last && ((st == ST_GEN) || (st == ST_PASS) || sof_here);
  assign tail_done  = (st == ST_TAIL) && out_ready && (tail_idx == IDX_LAST);

  // Hold occupancy after the push of the end byte decides where the tail starts.
  always_comb begin
    if (hold_clear)     cnt_after = CNT_W'(1);
    else if (hold_full) cnt_after = CNT_W'(TAIL_LEN);
    else                cnt_after = hold_count + CNT_W'(1);
    tidx_first = pass_now ? IDX_W'(TAIL_LEN - int'(cnt_after)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pass_q   <= 1'b0;
      tail_idx <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (sof_here && accept) begin
          pass_q <= in_pass;
          if (in_last) begin
            st       <= ST_TAIL;
            tail_idx <= tidx_first;
          end else begin
            st <= in_pass ? ST_PASS : ST_GEN;
          end
        end
        ST_GEN, ST_PASS: if (tail_go) begin
          st       <= ST_TAIL;
          tail_idx <= tidx_first;
        end
        ST_TAIL: if (out_ready) begin
          if (tail_idx == IDX_LAST) st <= ST_IDLE;
          else                      tail_idx <= tail_idx + IDX_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         unf_q <= 1'b0;
    else if (tail_done)                 unf_q <= 1'b0;
    else if (in_underflow && frame_open) unf_q <= 1'b1;
  end
endmodule

// File: rtl/fcs_tx_append.sv
module fcs_tx_append
  import fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_last,
  input  logic              in_pass,
  input  logic              in_underflow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  localparam int IDX_W = $clog2(FCS_LEN);
  localparam int CNT_W = $clog2(FCS_LEN + 1);

  out_sel_e          out_sel;
  fcs_state_e        st;
  logic              crc_start, crc_fold, hold_clear, hold_push, pass_q, unf_q;
  logic [IDX_W-1:0]  tail_idx, rd_idx;
  logic [CNT_W-1:0]  hold_count;
  logic [CRC_W-1:0]  crc_q;
  logic [BYTE_W-1:0] hold_rd, tail_byte;

  // Named internal events, used by the bound checker.
  logic st_idle, tail_active, pass_filling;
  assign st_idle      = (st == ST_IDLE);
  assign tail_active  = (st == ST_TAIL);
  assign pass_filling = (st == ST_PASS) && (hold_count != CNT_W'(FCS_LEN));

  fcs_tx_ctrl #(.TAIL_LEN(FCS_LEN)) u_ctrl (
    .clk, .rst_n, .in_valid, .in_sof, .in_last, .in_pass, .in_underflow, .out_ready,
    .hold_count, .in_ready, .out_valid, .out_last, .out_sel, .crc_start, .crc_fold,
    .hold_clear, .hold_push, .tail_idx, .pass_q, .unf_q, .st
  );

  fcs_crc_acc #(.DW(BYTE_W), .CW(CRC_W)) u_crc (
    .clk, .rst_n, .start(crc_start), .fold(crc_fold), .din(in_data), .crc_q
  );

  assign rd_idx = tail_active ? tail_idx : '0;

  fcs_tail_hold #(.DEPTH(FCS_LEN), .W(BYTE_W)) u_hold (
    .clk, .rst_n, .clear(hold_clear), .push(hold_push), .din(in_data),
    .rd_idx, .rd_data(hold_rd), .count(hold_count)
  );

  assign tail_byte = (pass_q ? hold_rd : fcs_lane(crc_q, int'(tail_idx))) ^ {BYTE_W{unf_q}};

  always_comb begin
    unique case (out_sel)
      SEL_IN:   out_data = in_data;
      SEL_HOLD: out_data = hold_rd;
      SEL_TAIL: out_data = tail_byte;
      default:  out_data = '0;
    endcase
  end
endmodule

// File: rtl/fcs_tx_append_chk.sv
module fcs_tx_append_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sof,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       st_idle,
  input logic       tail_active,
  input logic       pass_filling,
  input logic       pass_q,
  input logic       unf_q
);
  p_last_in_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> tail_active);

  p_unf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q && !st_idle |=> unf_q || st_idle);

  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !st_idle |=> st_idle || $stable(pass_q));

  p_idle_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && in_valid && !in_sof |-> in_ready && !out_valid);

  p_tail_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active && !out_ready |=> tail_active && out_valid && $stable(out_data));

  p_tail_blocks_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tail_active |-> !in_ready);

  p_fill_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pass_filling |-> !out_valid);
endmodule

bind fcs_tx_append fcs_tx_append_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .st_idle(st_idle), .tail_active(tail_active), .pass_filling(pass_filling),
  .pass_q(pass_q), .unf_q(unf_q)
);

// File: tb/test_fcs_tx_append.sv
`timescale 1ns/1ps
module test_fcs_tx_append;
  localparam int NONE = 255;

  typedef struct packed {
    logic [7:0] len;
    logic       pass;
    logic       crcok;
    logic [7:0] unf_at;
    logic [7:0] seed;
    logic       stall;
    logic       gaps;
    logic       ugap;
  } vec_t;

  // len, pass, crcok, unf_at, seed, stall, gaps, ugap
  localparam vec_t VECS [0:11] = '{
    '{8'd1,  1'b0, 1'b0, 8'd255, 8'h11, 1'b0, 1'b0, 1'b0},  // R2 single-byte frame
    '{8'd16, 1'b0, 1'b0, 8'd255, 8'h3C, 1'b0, 1'b0, 1'b0},  // R2
    '{8'd20, 1'b0, 1'b0, 8'd5,   8'h77, 1'b0, 1'b0, 1'b0},  // R6
    '{8'd12, 1'b1, 1'b1, 8'd255, 8'h05, 1'b0, 1'b0, 1'b0},  // R4, R8 clean after mark
    '{8'd12, 1'b1, 1'b0, 8'd255, 8'hA0, 1'b0, 1'b0, 1'b0},  // R5 wrong check bytes
    '{8'd14, 1'b1, 1'b1, 8'd13,  8'h42, 1'b0, 1'b0, 1'b0},  // R7 mark on end byte
    '{8'd30, 1'b0, 1'b0, 8'd255, 8'h99, 1'b1, 1'b1, 1'b0},  // R11
    '{8'd25, 1'b1, 1'b1, 8'd255, 8'h12, 1'b1, 1'b1, 1'b0},  // R11 pass
    '{8'd4,  1'b1, 1'b1, 8'd0,   8'hE1, 1'b1, 1'b0, 1'b0},  // R7 R12 minimum, mark on start
    '{8'd10, 1'b0, 1'b1, 8'd255, 8'h6B, 1'b0, 1'b0, 1'b0},  // R3 trailing valid check
    '{8'd20, 1'b0, 1'b0, 8'd255, 8'h2D, 1'b0, 1'b1, 1'b1},  // R8 mark in a gap
    '{8'd9,  1'b0, 1'b0, 8'd255, 8'h58, 1'b1, 1'b0, 1'b0}   // R8 clean after mark
  };

  logic       clk, rst_n;
  logic       in_valid, in_ready, in_sof, in_last, in_pass, in_underflow;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last;
  logic [7:0] out_data;

  fcs_tx_append i_fcs_tx_append (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_last, .in_pass,
    .in_underflow, .out_valid, .out_ready, .out_data, .out_last
  );

  int nchk = 0, nfail = 0, cyc = 0, ncap = 0, base = 0, exp_n = 0;
  logic [7:0] fb  [0:63];
  logic [7:0] xb  [0:71];
  logic [7:0] cap [0:2047];
  logic       capl[0:2047];
  bit         stall_en = 0;
  logic [7:0] lfsr = 8'h5A;

  initial clk = 0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_en ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && ncap < 2048) begin
      cap[ncap]  = out_data;
      capl[ncap] = out_last;
      ncap++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Bit-serial reference: shift out the low bit, apply the polynomial when it differs.
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (r[0] != fb[i][k]) r = (r >> 1) ^ 32'hEDB88320;
        else                  r = r >> 1;
      end
    end
    return ~r;
  endfunction

  task automatic fill(input int len, input logic [7:0] seed, input bit crcok);
    logic [31:0] c;
    for (int i = 0; i < len; i++) fb[i] = seed + 8'(i * 37);
    if (crcok) begin
      c = ref_fcs(len - 4);
      for (int k = 0; k < 4; k++) fb[len-4+k] = c[8*k +: 8];
    end
  endtask

  task automatic send_frame(input int len, input bit pass, input int unf_at,
                            input bit gaps, input bit ugap, output bit early);
    bit gap_done;
    gap_done = 0;
    early = 0;
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(posedge clk); #1;
        in_valid = 0; in_sof = 0; in_last = 0;
        in_underflow = ugap && !gap_done;
        gap_done = 1;
      end
      @(posedge clk); #1;
      in_valid = 1; in_data = fb[i]; in_sof = (i == 0); in_last = (i == len - 1);
      in_pass = (i == 0) ? pass : !pass;  // R9: later values must be ignored
      in_underflow = (i == unf_at);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (pass && i < 4 && out_valid) early = 1;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_last = 0; in_underflow = 0;
  endtask

  task automatic run_frame(input int len, input bit pass, input int unf_at,
                           input bit stall, input bit gaps, input bit ugap);
    bit unf, early;
    logic [31:0] c;
    logic [7:0] m;
    string req;
    int bad, nlast, lastpos, waitc;
    unf = (unf_at != NONE) || ugap;
    m = unf ? 8'hFF : 8'h00;
    req = pass ? (unf ? "R7" : "R4") : (unf ? "R6" : "R2");
    for (int i = 0; i < len; i++) xb[i] = fb[i];
    if (!pass) begin
      c = ref_fcs(len);
      for (int k = 0; k < 4; k++) xb[len+k] = c[8*k +: 8] ^ m;
      exp_n = len + 4;
    end else begin
      for (int i = (len > 4 ? len - 4 : 0); i < len; i++) xb[i] = fb[i] ^ m;
      exp_n = len;
    end
    stall_en = stall;
    base = ncap;
    send_frame(len, pass, unf_at, gaps, ugap, early);
    waitc = 0;
    while (ncap - base < exp_n && waitc < 3000) begin @(posedge clk); waitc++; end
    repeat (6) @(posedge clk);
    stall_en = 0;
    chk(ncap - base == exp_n, req, ncap - base, exp_n);
    bad = -1;
    for (int i = 0; i < exp_n; i++) if (bad < 0 && cap[base+i] !== xb[i]) bad = i;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, req, cap[base+bad], xb[bad]);
    nlast = 0; lastpos = -1;
    for (int i = 0; i < ncap - base; i++) if (capl[base+i]) begin nlast++; lastpos = i; end
    chk(nlast == 1 && lastpos == exp_n - 1, req, lastpos, exp_n - 1);
    if (pass) chk(!early, "R12", early, 0);
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_sof = 0; in_last = 0; in_pass = 0;
    in_underflow = 0; in_data = 0; out_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(in_ready == 1, "R1", in_ready, 1);

    // R10: stray bytes while idle are swallowed.
    base = ncap;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sof = 0; in_last = (i == 2); in_data = 8'hC0 + 8'(i); in_pass = 1;
      @(negedge clk);
      chk(in_ready == 1 && out_valid == 0, "R10", {in_ready, out_valid}, 2'b10);
    end
    @(posedge clk); #1 in_valid = 0; in_last = 0;
    repeat (4) @(posedge clk);
    chk(ncap == base, "R10", ncap - base, 0);

    // Table of vectors (R2..R9, R11, R12).
    for (int v = 0; v < 12; v++) begin
      fill(int'(VECS[v].len), VECS[v].seed, VECS[v].crcok);
      run_frame(int'(VECS[v].len), VECS[v].pass,
                (VECS[v].unf_at == 8'd255) ? NONE : int'(VECS[v].unf_at),
                VECS[v].stall, VECS[v].gaps, VECS[v].ugap);
    end

    // R2: known check value of the ASCII digits 1..9 is CBF43926.
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    run_frame(9, 0, NONE, 0, 0, 0);
    chk(cap[base+9]  == 8'h26, "R2", cap[base+9],  8'h26);
    chk(cap[base+10] == 8'h39, "R2", cap[base+10], 8'h39);
    chk(cap[base+11] == 8'hF4, "R2", cap[base+11], 8'hF4);
    chk(cap[base+12] == 8'hCB, "R2", cap[base+12], 8'hCB);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule